// File: doc/BRIEF.md
# Symmetric PWM Timer with Clock-Enable Prescaler

This block is an 8-bit timer that counts up from 0 to 255 and then back down to 1, over and over. It drives one output pin with a PWM waveform whose pulses are centred on the turning point at the top of the count. A prescaler divides the system clock into a count-enable strobe, so the counter moves at most once per prescaled period. The design has no second clock: the strobe only gates register updates on the single system clock. A period lasts 510 count steps, so the output frequency is the system clock divided by 510 times the division factor.

Software-side writes set the compare value, the division select together with the output polarity, and the counter itself. The block reports the live count, a sticky flag that marks each arrival at zero, and a sticky flag that marks each compare match. Both flags clear when 1 is written to them. The compare value is double-buffered and takes effect only at the top of the count. The two extreme compare values pin the output, and the output is forced low at the bottom of every period. This keeps the waveform symmetric after the compare value leaves 255, or after the counter is loaded past the match point.

Top module: `pcpwm_timer`

## Requirements
- R1: `ctl_psel` picks the division factor N: 0 stops counting and holds the count, and 1 to 7 give N = 1, 8, 32, 64, 128, 256 and 1024.
- R2: An accepted write that changes the select restarts the divider, so the first count step comes exactly N clocks after the write edge and none comes before it.
- R3: On each enabled step the count rises by one, except that it falls from 255 to 254 and rises from 0 to 1. It keeps falling after a fall until it reaches 0, so one period is 510 steps.
- R4: With polarity 0 and an active compare value k from 1 to 254, the output goes high when the count reaches k while rising and goes low when it reaches k while falling. With N = 1 this gives 510 - 2k high clocks per period.
- R5: An active compare value of 0 holds the non-inverted output low in every clock.
- R6: An active compare value of 255 holds the non-inverted output high in every clock.
- R7: Polarity 1 (`ctl_inv`) gives the exact complement of the polarity-0 output, including the pinned cases, so the high time becomes 2k clocks.
- R8: A compare write goes to a buffer. The active value takes the buffer contents only on the step that brings the count to 255.
- R9: The step that brings the count to 0 drives the output to its low non-inverted level, whether or not a match occurred. The output is therefore low at the first bottom after the compare value leaves 255. After a load past the match point, the next full period again has 510 - 2k high clocks.
- R10: `ovf_flag` sets on each step to 0 and `cmp_flag` sets on each step to the active compare value. Both stay set until a write with `flg_clr` bit 0 (overflow) or bit 1 (compare) at 1, and a set in the same cycle wins over the clear.
- R11: A counter write takes effect at the next edge, wins over a simultaneous step, raises no flag and keeps the count direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_we | input | 1 | Write strobe for the compare buffer |
| cmp_wdata | input | 8 | Compare value to buffer |
| ctl_we | input | 1 | Write strobe for select and polarity |
| ctl_psel | input | 3 | Division select (0 stops) |
| ctl_inv | input | 1 | Output polarity, 1 inverts |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wdata | input | 8 | Counter load value |
| flg_clr_we | input | 1 | Flag clear strobe |
| flg_clr | input | 2 | Bit 0 clears overflow, bit 1 clears compare |
| cnt_q | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky bottom-reached flag |
| cmp_flag | output | 1 | Sticky compare-match flag |
| pwm_out | output | 1 | PWM waveform |

## Verification
The properties assume that write strobes are single-cycle, synchronous pulses. They also assume that a counter load is the only thing that moves the count other than an enabled step, so the one-step property is written to exclude cycles that carry a load. The stimulus changes inputs only on falling clock edges, raises each strobe for exactly one cycle, and loads the counter only while it is stopped or where a test intends the load to win over a step. Every duty measurement starts at a bottom that comes after the new compare value has passed through a top, so the buffer update never falls inside the window being counted.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

  localparam int unsigned CNT_W  = 8;
  localparam int unsigned PSEL_W = 3;
  localparam int unsigned DIV_W  = 10;

  typedef enum logic [PSEL_W-1:0] {
    PS_STOP  = 3'd0,
    PS_D1    = 3'd1,
    PS_D8    = 3'd2,
    PS_D32   = 3'd3,
    PS_D64   = 3'd4,
    PS_D128  = 3'd5,
    PS_D256  = 3'd6,
    PS_D1024 = 3'd7
  } psel_e;

  typedef struct packed {
    logic cmp;
    logic ovf;
  } flag_t;

  // Terminal divider count (N - 1) for a select code.
  function automatic logic [15:0] div_limit(input logic [PSEL_W-1:0] sel);
    case (psel_e'(sel))
      PS_D8:    div_limit = 16'd7;
      PS_D32:   div_limit = 16'd31;
      PS_D64:   div_limit = 16'd63;
      PS_D128:  div_limit = 16'd127;
      PS_D256:  div_limit = 16'd255;
      PS_D1024: div_limit = 16'd1023;
      default:  div_limit = 16'd0;
    endcase
  endfunction

endpackage

// File: rtl/pcpwm_rst_sync.sv
module pcpwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pcpwm_prescaler.sv
module pcpwm_prescaler
  import pcpwm_pkg::*;
#(
  parameter int unsigned SEL_W = PSEL_W,
  parameter int unsigned DW    = DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  output logic [SEL_W-1:0] sel_q,
  output logic             tick
);

  logic [DW-1:0]    div_q, div_d, lim;
  logic [SEL_W-1:0] sel_d;
  logic             restart;

  always_comb begin
    lim     = DW'(div_limit(sel_q));
    restart = sel_we && (sel_wdata != sel_q);
    tick    = (sel_q != '0) && (div_q == lim);
    sel_d   = sel_we ? sel_wdata : sel_q;
    if (restart || sel_q == '0 || tick) div_d = '0;
    else                                div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sel_q <= '0;
    end else begin
      div_q <= div_d;
      sel_q <= sel_d;
    end
  end

endmodule

// File: rtl/pcpwm_updown_cnt.sv
module pcpwm_updown_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ld_we,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] nxt,
  output logic         step_up,
  output logic         adv,
  output logic         go_up_q
);

  localparam logic [W-1:0] TOPV = {W{1'b1}};

  logic [W-1:0] cnt_d;
  logic         go_up_d;

  always_comb begin
    step_up = (cnt_q == '0) || (go_up_q && (cnt_q != TOPV));
    nxt     = step_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
    adv     = tick && !ld_we;
    if (ld_we)    cnt_d = ld_data;
    else if (adv) cnt_d = nxt;
    else          cnt_d = cnt_q;
    go_up_d = adv ? step_up : go_up_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      go_up_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      go_up_q <= go_up_d;
    end
  end

endmodule

// File: rtl/pcpwm_wavegen.sv
module pcpwm_wavegen #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] nxt,
  input  logic         step_up,
  input  logic         buf_we,
  input  logic [W-1:0] buf_wdata,
  input  logic         inv,
  output logic [W-1:0] ocr_act_q,
  output logic         match,
  output logic         bottom,
  output logic         pwm
);

  localparam logic [W-1:0] TOPV = {W{1'b1}};

  logic [W-1:0] ocr_buf_q, ocr_buf_d, ocr_act_d;
  logic         lvl_q, lvl_d, top, wave;

  always_comb begin
    match     = adv && (nxt == ocr_act_q);
    bottom    = adv && (nxt == '0);
    top       = adv && (nxt == TOPV);
    ocr_buf_d = buf_we ? buf_wdata : ocr_buf_q;
    ocr_act_d = top ? ocr_buf_q : ocr_act_q;
    if (bottom)     lvl_d = 1'b0;
    else if (match) lvl_d = step_up;
    else            lvl_d = lvl_q;
  end

  always_comb begin
    if (ocr_act_q == '0)        wave = 1'b0;
    else if (ocr_act_q == TOPV) wave = 1'b1;
    else                        wave = lvl_q;
    pwm = wave ^ inv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocr_buf_q <= '0;
      ocr_act_q <= '0;
      lvl_q     <= 1'b0;
    end else begin
      ocr_buf_q <= ocr_buf_d;
      ocr_act_q <= ocr_act_d;
      lvl_q     <= lvl_d;
    end
  end

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
  import pcpwm_pkg::*;
#(
  parameter int unsigned W     = CNT_W,
  parameter int unsigned SEL_W = PSEL_W,
  parameter int unsigned DW    = DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_we,
  input  logic [W-1:0]     cmp_wdata,
  input  logic             ctl_we,
  input  logic [SEL_W-1:0] ctl_psel,
  input  logic             ctl_inv,
  input  logic             cnt_we,
  input  logic [W-1:0]     cnt_wdata,
  input  logic             flg_clr_we,
  input  logic [1:0]       flg_clr,
  output logic [W-1:0]     cnt_q,
  output logic             ovf_flag,
  output logic             cmp_flag,
  output logic             pwm_out
);

  logic             rst_sync_n;
  logic [SEL_W-1:0] psel;
  logic             tick, adv, step_up, go_up, match, bottom;
  logic [W-1:0]     nxt, ocr_act;
  logic             ctl_inv_q, ctl_inv_d;
  flag_t            flags_q, flags_d, flag_set, flag_clr_v;

  pcpwm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pcpwm_prescaler #(.SEL_W(SEL_W), .DW(DW)) u_psc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel_we    (ctl_we),
    .sel_wdata (ctl_psel),
    .sel_q     (psel),
    .tick      (tick)
  );

  pcpwm_updown_cnt #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (tick),
    .ld_we   (cnt_we),
    .ld_data (cnt_wdata),
    .cnt_q   (cnt_q),
    .nxt     (nxt),
    .step_up (step_up),
    .adv     (adv),
    .go_up_q (go_up)
  );

  pcpwm_wavegen #(.W(W)) u_wave (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .adv       (adv),
    .nxt       (nxt),
    .step_up   (step_up),
    .buf_we    (cmp_we),
    .buf_wdata (cmp_wdata),
    .inv       (ctl_inv_q),
    .ocr_act_q (ocr_act),
    .match     (match),
    .bottom    (bottom),
    .pwm       (pwm_out)
  );

  always_comb begin
    ctl_inv_d      = ctl_we ? ctl_inv : ctl_inv_q;
    flag_set.ovf   = bottom;
    flag_set.cmp   = match;
    flag_clr_v.ovf = flg_clr_we && flg_clr[0];
    flag_clr_v.cmp = flg_clr_we && flg_clr[1];
    flags_d        = (flags_q & ~flag_clr_v) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_inv_q <= 1'b0;
      flags_q   <= '0;
    end else begin
      ctl_inv_q <= ctl_inv_d;
      flags_q   <= flags_d;
    end
  end

  assign ovf_flag = flags_q.ovf;
  assign cmp_flag = flags_q.cmp;

endmodule

// File: rtl/pcpwm_timer_chk.sv
module pcpwm_timer_chk #(
  parameter int unsigned W     = 8,
  parameter int unsigned SEL_W = 3
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             tick,
  input logic             cnt_we,
  input logic [W-1:0]     cnt_wdata,
  input logic [W-1:0]     cnt_q,
  input logic             go_up,
  input logic [W-1:0]     ocr_act,
  input logic             ctl_inv_q,
  input logic             pwm_out,
  input logic             ovf_flag,
  input logic             flg_clr_we,
  input logic [1:0]       flg_clr,
  input logic [SEL_W-1:0] psel
);

  localparam logic [W-1:0] TOPV = {W{1'b1}};

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (psel == '0 && !cnt_we) |=> $stable(cnt_q)); // R1

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick && !cnt_we) |=> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == $past(cnt_q) - 1'b1)); // R3

  AST_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ocr_act == '0) |-> (pwm_out == ctl_inv_q)); // R5

  AST_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ocr_act == TOPV) |-> (pwm_out == !ctl_inv_q)); // R6

  AST_ACT_AT_TOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ocr_act != $past(ocr_act)) |-> (cnt_q == TOPV)); // R8

  AST_BOTTOM_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick && !cnt_we && cnt_q == 1 && !go_up) |=> ovf_flag); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovf_flag && !(flg_clr_we && flg_clr[0])) |=> ovf_flag); // R10

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cnt_we |=> (cnt_q == $past(cnt_wdata))); // R11

endmodule

bind pcpwm_timer pcpwm_timer_chk #(.W(W), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .tick       (tick),
  .cnt_we     (cnt_we),
  .cnt_wdata  (cnt_wdata),
  .cnt_q      (cnt_q),
  .go_up      (go_up),
  .ocr_act    (ocr_act),
  .ctl_inv_q  (ctl_inv_q),
  .pwm_out    (pwm_out),
  .ovf_flag   (ovf_flag),
  .flg_clr_we (flg_clr_we),
  .flg_clr    (flg_clr),
  .psel       (psel)
);

// File: tb/pcpwm_timer_tb.sv
`timescale 1ns/1ps
module pcpwm_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmp_we = 1'b0, ctl_we = 1'b0, cnt_we = 1'b0, flg_clr_we = 1'b0;
  logic [7:0] cmp_wdata = '0, cnt_wdata = '0;
  logic [2:0] ctl_psel = '0;
  logic       ctl_inv = 1'b0;
  logic [1:0] flg_clr = '0;
  logic [7:0] cnt_q;
  logic       ovf_flag, cmp_flag, pwm_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  pcpwm_timer u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .ctl_we(ctl_we), .ctl_psel(ctl_psel), .ctl_inv(ctl_inv),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .flg_clr_we(flg_clr_we), .flg_clr(flg_clr),
    .cnt_q(cnt_q), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .pwm_out(pwm_out)
  );

  // {compare, polarity, expected high clocks per period with N = 1}
  localparam int NVEC = 10;
  localparam logic [8:0] VCMP [NVEC] = '{9'd0, 9'd255, 9'd1, 9'd254, 9'd128,
                                         9'd100, 9'd0, 9'd255, 9'd37, 9'd200};
  localparam logic       VINV [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                         1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam int         VHI  [NVEC] = '{0, 510, 508, 2, 254,
                                         200, 510, 0, 436, 400};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic wr_ctl(input logic [2:0] s, input logic inv);
    ctl_psel = s; ctl_inv = inv; ctl_we = 1'b1;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_cmp(input logic [7:0] v);
    cmp_wdata = v; cmp_we = 1'b1;
    @(negedge clk); cmp_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    cnt_wdata = v; cnt_we = 1'b1;
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic clr_flags(input logic [1:0] m);
    flg_clr = m; flg_clr_we = 1'b1;
    @(negedge clk); flg_clr_we = 1'b0;
  endtask

  task automatic wait_cnt(input logic [7:0] v);
    while (cnt_q != v) @(negedge clk);
  endtask

  // Count high samples over one period starting at bottom.
  task automatic measure(output int hi);
    hi = 0;
    wait_cnt(8'd0);
    for (int i = 0; i < 510; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    int hi;
    logic [7:0] held;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state
    check("R1 reset count", cnt_q, 0);
    check("R10 reset flags", {ovf_flag, cmp_flag}, 0);
    check("R5 reset output", pwm_out, 0);

    // R2 / R1: each select gives its step after exactly N clocks
    for (int s = 1; s <= 7; s++) begin
      int n;
      case (s)
        1: n = 1;   2: n = 8;   3: n = 32;  4: n = 64;
        5: n = 128; 6: n = 256; default: n = 1024;
      endcase
      wr_ctl(3'd0, 1'b0);
      wr_cnt(8'd0);
      wr_ctl(3'(s), 1'b0);
      repeat (n - 1) @(negedge clk);
      check($sformatf("R2 no step before N=%0d", n), cnt_q, 0);
      @(negedge clk);
      check($sformatf("R1 step at N=%0d", n), cnt_q, 1);
    end

    // R1: select 0 stops
    wr_ctl(3'd0, 1'b0);
    held = cnt_q;
    repeat (3000) @(negedge clk);
    check("R1 stopped count held", cnt_q, held);

    // R3: turn-around at top and bottom
    wr_cnt(8'd254);
    wr_ctl(3'd1, 1'b0);
    wait_cnt(8'd255); @(negedge clk);
    check("R3 falls after 255", cnt_q, 254);
    wait_cnt(8'd0); @(negedge clk);
    check("R3 rises after 0", cnt_q, 1);

    // Vector table: duty, pinned extremes and polarity
    for (int v = 0; v < NVEC; v++) begin
      wr_ctl(3'd1, VINV[v]);
      wr_cmp(VCMP[v][7:0]);
      wait_cnt(8'd0);
      wait_cnt(8'd255);
      measure(hi);
      check($sformatf("R4 R5 R6 R7 duty cmp=%0d inv=%0d", VCMP[v], VINV[v]), hi, VHI[v]);
    end

    // R10: flags
    wr_ctl(3'd1, 1'b0);
    wr_cmp(8'd100);
    wait_cnt(8'd0); wait_cnt(8'd255);
    wait_cnt(8'd5);
    clr_flags(2'b11);
    check("R10 cleared flags", {ovf_flag, cmp_flag}, 0);
    wait_cnt(8'd100);
    check("R10 cmp flag on match", cmp_flag, 1);
    wait_cnt(8'd0);
    check("R10 ovf flag at bottom", ovf_flag, 1);
    repeat (20) @(negedge clk);
    check("R10 ovf flag sticky", ovf_flag, 1);
    clr_flags(2'b01);
    check("R10 ovf cleared by write", ovf_flag, 0);
    check("R10 cmp kept when not cleared", cmp_flag, 1);

    // R11 / R9: load past the match point
    wait_cnt(8'd150);
    clr_flags(2'b11);
    wr_cnt(8'd200);
    check("R11 load wins over step", cnt_q, 200);
    check("R11 load raises no flag", {ovf_flag, cmp_flag}, 0);
    wait_cnt(8'd0);
    check("R9 low at bottom after load", pwm_out, 0);
    measure(hi);
    check("R9 symmetric period after load", hi, 310);

    // R9: leaving 255
    wr_cmp(8'd255);
    wait_cnt(8'd0); wait_cnt(8'd255); wait_cnt(8'd20);
    check("R6 pinned high", pwm_out, 1);
    wr_cmp(8'd128);
    wait_cnt(8'd0); wait_cnt(8'd255);
    wait_cnt(8'd0);
    check("R9 low at first bottom after leaving 255", pwm_out, 0);

    // R8: buffered update only at top
    wait_cnt(8'd10);
    wr_cmp(8'd0);
    wait_cnt(8'd200);
    check("R8 old compare still active", pwm_out, 1);
    wait_cnt(8'd255);
    check("R8 new compare active at top", pwm_out, 0);

    done = 1'b1;
    finish_run();
  end

endmodule